// File: doc/BRIEF.md
# I2C Serial Byte Memory Target

This block is an I2C target that serves a small byte memory and a separate 8-bit configuration byte. It oversamples SCL and SDA with the system clock and finds Start and Stop conditions. It pulls SDA low through an open-drain enable to acknowledge bytes and to return read data. Memory is selected by type code `1010` in the top nibble of the header byte and the configuration byte by a second type code. In both cases header bits 3..1 must equal a chip-select parameter, and header bit 0 gives the direction (1 = read).

A memory write sends a header, a word address and one or more data bytes. The data bytes are held in a page buffer and are not visible yet. A Stop that follows at least one complete data byte starts an internal write cycle of `WR_CYCLES` system clocks. During that cycle the target ignores the bus completely. At the end of the cycle the buffered bytes are copied into the array. Reads send a header and a word address, then a repeated Start and a read header. A read header with no address before it reads from the current counter. The configuration byte is written with one data byte and no address, and is read back as a single byte.

Top module: `i2c_serial_mem`

## Requirements
- R1: After reset, SDA is released, every memory byte reads `MEM_RST` (default 0xFF) and the configuration byte reads `CFG_RST` (default 0x00).
- R2: A header whose bits 7..4 equal 1010 (memory) or `CFG_TYPE` (default 1011), and whose bits 3..1 equal `CHIP_SEL`, is acknowledged by holding SDA low for the 9th SCL pulse. SDA is only pulled low while SCL is low. Any other header is not acknowledged, and the target then stays off the bus until the next Start.
- R3: A byte write (memory header with bit 0 = 0, word address, one data byte, Stop) makes that byte readable at that address once the write cycle has ended.
- R4: In a page write, each data byte goes to the current address, and then only the low 4 address bits advance. The upper address bits stay as the address byte set them, so bytes outside the 16-byte page are untouched.
- R5: When more than 16 data bytes arrive before the Stop, the low address bits wrap around and later bytes overwrite earlier ones in the same page.
- R6: A Stop after a write with at least one complete data byte starts a write cycle lasting `WR_CYCLES` system clocks. During that cycle no header is acknowledged and SDA is never pulled. After the cycle, headers are acknowledged again.
- R7: A repeated Start before the Stop discards data bytes written in that transfer. No write cycle follows, and the array keeps its old contents.
- R8: A random read (write header, word address, repeated Start, read header) returns the byte at that address MSB first. A write that carries only an address and then a Stop starts no write cycle.
- R9: In a read, the address counter advances by one, wrapping at the top of the array, after each byte the master acknowledges. A byte the master does not acknowledge leaves the counter unchanged, and the target then releases SDA. A read header with no address before it reads the byte at the counter.
- R10: A configuration write takes exactly one data byte after its header. That byte is acknowledged and a further byte is not. The new value takes effect when the write cycle ends.
- R11: A configuration read returns the configuration byte MSB first and leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |

## Verification
The checks assume that every SCL and SDA level lasts several system clocks, so that the two-flop synchronisers see each edge. They also assume that SDA changes only while SCL is low, except for Start and Stop, and that the master never issues Start or Stop while the target is driving. The bench drives the bus in quarter-bit steps of eight system clocks and changes SDA only in the middle of an SCL low phase. It always releases SDA before an acknowledge or read slot. The write cycle is set long enough that a header sent right after the Stop falls inside it.

// File: rtl/i2c_serial_mem_pkg.sv
package i2c_serial_mem_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_st_e;
  typedef enum logic [2:0] {PH_HDR, PH_WADDR, PH_WDATA, PH_CFGD, PH_SPENT} rx_ph_e;
  localparam logic [3:0] MEM_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_serial_mem_lines.sv
module i2c_serial_mem_lines #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sr[SYNC_STAGES-1];
      sda_q  <= sda_sr[SYNC_STAGES-1];
    end
  end

  assign scl_hi    = scl_sr[SYNC_STAGES-1];
  assign sda_bit   = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_hi & ~scl_q;
  assign scl_fall  = ~scl_hi & scl_q;
  assign start_det = scl_hi & scl_q & sda_q & ~sda_bit;
  assign stop_det  = scl_hi & scl_q & ~sda_q & sda_bit;
endmodule

// File: rtl/i2c_serial_mem_wtimer.sv
module i2c_serial_mem_wtimer #(
  parameter int WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      left <= '0;
    else if (kick && left == '0)     left <= CW'(WR_CYCLES);
    else if (left != '0)             left <= left - CW'(1);
  end

  assign busy = (left != '0);
  assign done = (left == CW'(1));
endmodule

// File: rtl/i2c_serial_mem_store.sv
module i2c_serial_mem_store #(
  parameter int DEPTH = 256,
  parameter int PAGE  = 16,
  parameter logic [7:0] MEM_RST = 8'hFF,
  parameter logic [7:0] CFG_RST = 8'h00
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stage_mem,
  input  logic                     stage_cfg,
  input  logic [$clog2(DEPTH)-1:0] stage_addr,
  input  logic [7:0]               din,
  input  logic                     commit,
  input  logic                     discard,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [7:0]               rd_data,
  output logic [7:0]               cfg_q,
  output logic                     pend
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(PAGE);

  logic [7:0]      mem    [DEPTH];
  logic [7:0]      lane_d [PAGE];
  logic [PAGE-1:0] lane_v;
  logic [AW-LW-1:0] base;
  logic [7:0]      cfg_buf;
  logic            cfg_v;

  // staging of page bytes and the configuration byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_v  <= '0;
      base    <= '0;
      cfg_v   <= 1'b0;
      cfg_buf <= '0;
    end else if (commit || discard) begin
      lane_v <= '0;
      cfg_v  <= 1'b0;
    end else begin
      if (stage_mem) begin
        lane_v[stage_addr[LW-1:0]] <= 1'b1;
        base <= stage_addr[AW-1:LW];
      end
      if (stage_cfg) begin
        cfg_v   <= 1'b1;
        cfg_buf <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stage_mem) lane_d[stage_addr[LW-1:0]] <= din;
  end

  // array update at the end of the write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= MEM_RST;
    end else if (commit) begin
      for (int l = 0; l < PAGE; l++)
        if (lane_v[l]) mem[{base, LW'(l)}] <= lane_d[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cfg_q <= CFG_RST;
    else if (commit && cfg_v)  cfg_q <= cfg_buf;
  end

  assign rd_data = mem[rd_addr];
  assign pend    = (|lane_v) | cfg_v;
endmodule

// File: rtl/i2c_serial_mem.sv
module i2c_serial_mem
  import i2c_serial_mem_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int PAGE      = 16,
  parameter int WR_CYCLES = 2000,
  parameter logic [3:0] CFG_TYPE = 4'b1011,
  parameter logic [2:0] CHIP_SEL = 3'b000,
  parameter logic [7:0] MEM_RST  = 8'hFF,
  parameter logic [7:0] CFG_RST  = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(PAGE);

  logic scl_hi, sda_bit, scl_rise, scl_fall, start_det, stop_det;
  logic busy, done, pend;
  logic [7:0] rd_data, cfg_q, tx_byte;

  bus_st_e   state;
  rx_ph_e    ph;
  logic [3:0] cnt;
  logic [2:0] txi;
  logic [7:0] shreg;
  logic [AW-1:0] addr;
  logic rd_cfg, go_tx, mack;

  i2c_serial_mem_lines #(.SYNC_STAGES(2)) u_lines (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // byte boundary decisions
  logic byte_end, hdr_mem, hdr_cfg, byte_ok;
  assign byte_end = (state == ST_RX) && scl_fall && (cnt == 4'd8)
                    && !busy && !start_det && !stop_det;
  assign hdr_mem  = (shreg[7:4] == MEM_TYPE) && (shreg[3:1] == CHIP_SEL);
  assign hdr_cfg  = (shreg[7:4] == CFG_TYPE) && (shreg[3:1] == CHIP_SEL);
  always_comb begin
    case (ph)
      PH_HDR:   byte_ok = hdr_mem | hdr_cfg;
      PH_SPENT: byte_ok = 1'b0;
      default:  byte_ok = 1'b1;
    endcase
  end

  logic stage_mem, stage_cfg, kick, discard;
  assign stage_mem = byte_end && (ph == PH_WDATA);
  assign stage_cfg = byte_end && (ph == PH_CFGD);
  assign kick      = stop_det && !busy && pend;
  assign discard   = start_det && !busy;

  i2c_serial_mem_wtimer #(.WR_CYCLES(WR_CYCLES)) u_wtimer (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy), .done(done)
  );

  i2c_serial_mem_store #(.DEPTH(DEPTH), .PAGE(PAGE), .MEM_RST(MEM_RST), .CFG_RST(CFG_RST)) u_store (
    .clk(clk), .rst_n(rst_n), .stage_mem(stage_mem), .stage_cfg(stage_cfg),
    .stage_addr(addr), .din(shreg), .commit(done), .discard(discard),
    .rd_addr(addr), .rd_data(rd_data), .cfg_q(cfg_q), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ph     <= PH_HDR;
      cnt    <= '0;
      txi    <= 3'd7;
      shreg  <= '0;
      addr   <= '0;
      rd_cfg <= 1'b0;
      go_tx  <= 1'b0;
      mack   <= 1'b0;
    end else if (busy) begin
      state <= ST_IDLE;
      ph    <= PH_HDR;
      cnt   <= '0;
    end else if (start_det) begin
      state <= ST_RX;
      ph    <= PH_HDR;
      cnt   <= '0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      ph    <= PH_HDR;
      cnt   <= '0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && cnt < 4'd8) begin
            shreg <= {shreg[6:0], sda_bit};
            cnt   <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            if (byte_ok) begin
              state <= ST_ACK;
              go_tx <= 1'b0;
              case (ph)
                PH_HDR: begin
                  rd_cfg <= hdr_cfg;
                  go_tx  <= shreg[0];
                  if (!shreg[0]) ph <= hdr_cfg ? PH_CFGD : PH_WADDR;
                end
                PH_WADDR: begin
                  addr <= shreg[AW-1:0];
                  ph   <= PH_WDATA;
                end
                PH_WDATA: addr <= {addr[AW-1:LW], addr[LW-1:0] + LW'(1)};
                default:  ph <= PH_SPENT;
              endcase
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            txi <= 3'd7;
            state <= go_tx ? ST_TX : ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              state <= ST_MACK;
              mack  <= 1'b0;
            end else begin
              txi <= txi - 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack <= ~sda_bit;
          else if (scl_fall) begin
            if (mack && !rd_cfg) begin
              addr  <= addr + AW'(1);
              state <= ST_TX;
              txi   <= 3'd7;
              cnt   <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign tx_byte = rd_cfg ? cfg_q : rd_data;
  assign sda_oe  = (state == ST_ACK) || ((state == ST_TX) && !tx_byte[txi]);
endmodule

// File: rtl/i2c_serial_mem_chk.sv
module i2c_serial_mem_chk
  import i2c_serial_mem_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          busy,
  input logic          stop_det,
  input logic          scl_hi,
  input bus_st_e       state,
  input rx_ph_e        ph,
  input logic [AW-1:0] addr
);
  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_oe);
  // R6
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(stop_det));
  // R6
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> state == ST_IDLE);
  // R2
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_hi);
  // R4
  page_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && ph == PH_WDATA && $past(state != ST_IDLE && ph == PH_WDATA))
    |-> $stable(addr[AW-1:LW]));
  // R9
  tx_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && $past(state == ST_TX)) |-> $stable(addr));
endmodule

bind i2c_serial_mem i2c_serial_mem_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .busy(busy), .stop_det(stop_det),
  .scl_hi(scl_hi), .state(state), .ph(ph), .addr(addr)
);

// File: tb/tb_i2c_serial_mem.sv
module tb_i2c_serial_mem;
  localparam int CLK_PERIOD = 10;
  localparam int Q   = 8;
  localparam int WRC = 1000;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  int checks = 0, errors = 0;
  logic [7:0] rbuf [20];

  assign sda_line = sda_m & ~sda_oe;

  i2c_serial_mem #(.WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bus_wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(Q); tick(Q); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rd(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); scl = 1'b0; tick(Q);
    end
    sda_m = ~give_ack; tick(Q); scl = 1'b1; tick(Q); tick(Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_ack(input logic [7:0] b, input logic exp, input string tag);
    logic a;
    bus_wr(b, a);
    chk8(tag, {7'd0, a}, {7'd0, exp});
  endtask

  task automatic read_seq(input logic [7:0] a, input int n);
    bus_start;
    wr_ack(8'hA0, 1'b1, "R8 write header ack");
    wr_ack(a, 1'b1, "R8 address ack");
    bus_start;
    wr_ack(8'hA1, 1'b1, "R8 read header ack");
    for (int i = 0; i < n; i++) bus_rd(i != n - 1, rbuf[i]);
    bus_stop;
  endtask

  task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] first);
    bus_start;
    wr_ack(8'hA0, 1'b1, "R3 header ack");
    wr_ack(a, 1'b1, "R3 address ack");
    for (int i = 0; i < n; i++) wr_ack(first + 8'(i), 1'b1, "R4 data ack");
    bus_stop;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk8("R1 SDA released", {7'd0, sda_line}, 8'd1);
    bus_start;
    wr_ack(8'hB1, 1'b1, "R1 config header ack");
    bus_rd(1'b0, v);
    bus_stop;
    chk8("R1 config reset value", v, 8'h00);
    read_seq(8'h37, 2);
    chk8("R1 memory reset 0x37", rbuf[0], 8'hFF);
    chk8("R1 memory reset 0x38", rbuf[1], 8'hFF);
    bus_start;
    wr_ack(8'hA0, 1'b1, "R8 no write cycle after address-only write");
    bus_stop;
  endtask

  task automatic t_bad_hdr;
    bus_start;
    wr_ack(8'h30, 1'b0, "R2 foreign type code");
    wr_ack(8'hA0, 1'b0, "R2 ignored until next start");
    bus_stop;
    bus_start;
    wr_ack(8'hA2, 1'b0, "R2 chip select mismatch");
    bus_stop;
    bus_start;
    wr_ack(8'hA0, 1'b1, "R2 matching header");
    bus_stop;
  endtask

  task automatic t_byte_write;
    write_seq(8'h42, 1, 8'h5A);
    bus_start;
    wr_ack(8'hA0, 1'b0, "R6 header ignored during write cycle");
    bus_stop;
    tick(WRC + 50);
    read_seq(8'h42, 1);
    chk8("R3 byte write readback", rbuf[0], 8'h5A);
  endtask

  task automatic t_page_write;
    logic [7:0] e;
    write_seq(8'h25, 18, 8'h80);
    tick(WRC + 50);
    read_seq(8'h20, 16);
    for (int l = 0; l < 16; l++) begin
      if (l == 5)      e = 8'h90;
      else if (l == 6) e = 8'h91;
      else             e = 8'h80 + 8'((l + 11) % 16);
      chk8((l == 5 || l == 6) ? "R5 page wrap overwrite" : "R4 page lane", rbuf[l], e);
    end
    read_seq(8'h1F, 1);
    chk8("R4 byte below page untouched", rbuf[0], 8'hFF);
    read_seq(8'h30, 1);
    chk8("R4 byte above page untouched", rbuf[0], 8'hFF);
  endtask

  task automatic t_seq_wrap;
    logic [7:0] v;
    write_seq(8'hFF, 1, 8'hC3);
    tick(WRC + 50);
    write_seq(8'h00, 1, 8'h3C);
    tick(WRC + 50);
    read_seq(8'hFF, 2);
    chk8("R9 read at top", rbuf[0], 8'hC3);
    chk8("R9 counter wraps to 0", rbuf[1], 8'h3C);
    bus_start;
    wr_ack(8'hA1, 1'b1, "R9 current read header");
    bus_rd(1'b0, v);
    bus_stop;
    chk8("R9 NACKed byte keeps counter", v, 8'h3C);
  endtask

  task automatic t_rs_discard;
    logic [7:0] v;
    bus_start;
    wr_ack(8'hA0, 1'b1, "R7 header");
    wr_ack(8'h50, 1'b1, "R7 address");
    wr_ack(8'h77, 1'b1, "R7 data");
    bus_start;
    wr_ack(8'hA1, 1'b1, "R7 read after repeated start");
    bus_rd(1'b0, v);
    bus_stop;
    chk8("R7 next byte still erased", v, 8'hFF);
    bus_start;
    wr_ack(8'hA0, 1'b1, "R7 no write cycle started");
    wr_ack(8'h50, 1'b1, "R7 address");
    bus_start;
    wr_ack(8'hA1, 1'b1, "R7 read header");
    bus_rd(1'b0, v);
    bus_stop;
    chk8("R7 discarded byte not stored", v, 8'hFF);
  endtask

  task automatic t_cfg;
    logic [7:0] v;
    bus_start;
    wr_ack(8'hB0, 1'b1, "R10 config write header");
    wr_ack(8'h6D, 1'b1, "R10 config data byte");
    wr_ack(8'h12, 1'b0, "R10 extra byte refused");
    bus_stop;
    tick(WRC + 50);
    bus_start;
    wr_ack(8'hB1, 1'b1, "R11 config read header");
    bus_rd(1'b0, v);
    bus_stop;
    chk8("R11 config value", v, 8'h6D);
    read_seq(8'h42, 1);
    chk8("R11 memory unchanged", rbuf[0], 8'h5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_bad_hdr;
    t_byte_write;
    t_page_write;
    t_seq_wrap;
    t_rs_discard;
    t_cfg;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule